// File: doc/BRIEF.md
# Two-Level Page Translation Walker

This block turns a 32-bit linear address into a physical page frame for a 32-bit, non-extended paging scheme. It reads a directory entry and then, for ordinary 4 KB mappings, a table entry. It does this through a single word-wide memory port that carries one request at a time. When large pages are enabled and the directory entry asks for one, the walk stops after the first level and maps a 4 MB region.

Along the way the walker enforces user and write rights. It stores the accessed and dirty flags back into memory only when an entry actually changes. At the end it reports either a translation (frame, large-page flag, write right) or a page-fault code together with the faulting address. The caller gives a one-cycle start pulse with the address, the access kind and the paging controls, and waits for a one-cycle done pulse. The result outputs stay steady until the next walk completes.

Entry bit meanings used throughout: bit 0 present, bit 1 writable, bit 2 user, bit 5 accessed, bit 6 dirty, bit 7 large page. Fault code bits: bit 0 = 1 for a protection violation and 0 for a missing entry, bit 1 = write access, bit 2 = user access.

Top module: `pt_walker`

## Requirements
- R1: With paging_on low, a walk makes no memory access and reports frame = walk_va[31:12] ANDed with a20_keep[31:12], can_write = 1, no fault and big_page = 0.
- R2: The first read goes to ((dir_base & ~0xFFF) + walk_va[31:22]*4) & a20_keep.
- R3: For a 4 KB mapping the second read goes to ((directory entry & ~0xFFF) + walk_va[21:12]*4) & a20_keep.
- R4: If the directory entry has bit 7 set and big_pages_on is 1, no table read follows, big_page = 1 and frame = {entry[31:22], walk_va[21:12]} & a20_keep[31:12]; with big_pages_on = 0, bit 7 is ignored and the table is read.
- R5: The effective user (bit 2) and writable (bit 1) rights of a 4 KB mapping are the AND of both entries. A user access faults without the user right, or on a write without the writable right. A supervisor write without the writable right faults only when wr_protect is 1.
- R6: A fault is reported with walk_fault = 1, fault_code bit 0 = 0 for a non-present entry (bit 0 clear) and 1 for a rights violation, bit 1 = walk_wr, bit 2 = walk_usr, fault_va = walk_va and can_write = 0.
- R7: A successful walk sets bit 5 in every entry it reads and sets bit 6 in the final entry on a write. A 4 KB directory entry gets only bit 5. An entry is written back only if its value changes.
- R8: can_write is 1 only when the final entry (after update) has bit 6 set and the rights allow a write. For a supervisor access with wr_protect = 0, the rights always allow it.
- R9: Every entry address and every reported frame is ANDed with a20_keep.
- R10: mem_req stays high with a stable mem_addr until mem_ack. mem_we only comes with mem_req. walk_busy and walk_done are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| walk_start | input | 1 | Start pulse, taken when idle |
| walk_va | input | 32 | Linear address to translate |
| walk_wr | input | 1 | Access is a write |
| walk_usr | input | 1 | Access is at user privilege |
| paging_on | input | 1 | Paging enable |
| wr_protect | input | 1 | Supervisor write protection enable |
| big_pages_on | input | 1 | Large-page enable |
| dir_base | input | 32 | Directory base register |
| a20_keep | input | 32 | Address mask applied to memory and frame addresses |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Entry byte address |
| mem_wdata | output | 32 | Updated entry |
| mem_ack | input | 1 | Request completed; read data valid |
| mem_rdata | input | 32 | Entry read data |
| walk_busy | output | 1 | Walk in progress |
| walk_done | output | 1 | One-cycle completion pulse |
| walk_fault | output | 1 | Walk ended in a page fault |
| fault_code | output | 3 | Fault code |
| fault_va | output | 32 | Faulting linear address |
| phys_frame | output | 20 | Physical 4 KB frame number |
| big_page | output | 1 | Mapping came from a large page |
| can_write | output | 1 | Write allowed through this mapping |

## Verification
The walk is driven with a user read and then a user write of a clean 4 KB page. The pair separates the accessed-only update of the directory entry from the dirty update of the table entry, and it shows write permission appearing only once the page is dirty. A page missing the user right, an absent directory entry, and a read-only page written by the supervisor under each protection setting each give a distinct fault code. Together they separate the P, W and U bits and the effect of the protection enable. The same large directory entry is walked with large pages on and off, which shows whether the table read is skipped. A final walk uses a base and a page frame both carrying address bit 20 under a cleared mask, which shows the mask on entry addresses and on frames.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  localparam int BIT_PRES  = 0;
  localparam int BIT_RW    = 1;
  localparam int BIT_USR   = 2;
  localparam int BIT_ACC   = 5;
  localparam int BIT_DIRTY = 6;
  localparam int BIT_BIG   = 7;
  localparam int ERR_W     = 3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DIR_RD, ST_DIR_WB, ST_TBL_GO, ST_TBL_RD, ST_TBL_WB, ST_FIN
  } walk_st_e;
endpackage

// File: rtl/pt_walker_ent_addr.sv
module pt_walker_ent_addr #(
  parameter int AW    = 32,
  parameter int OFF_W = 12,
  parameter int IDX_W = 10
) (
  input  logic [AW-1:0]    base_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [AW-1:0]    keep_i,
  output logic [AW-1:0]    addr_o
);
  localparam int SLOT_W = IDX_W + 2;

  logic [AW-1:0] frame_base;
  logic [AW-1:0] slot_off;

  always_comb begin
    frame_base = {base_i[AW-1:OFF_W], {OFF_W{1'b0}}};
    slot_off   = AW'({idx_i, 2'b00});
    addr_o     = (frame_base + slot_off) & keep_i;
  end

  initial begin
    a_r2_slot_fits: assert (SLOT_W <= OFF_W);
  end
endmodule

// File: rtl/pt_walker_rights.sv
module pt_walker_rights
  import pt_walker_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] ent_i,
  input  logic [AW-1:0] dir_i,
  input  logic          combine_i,
  input  logic          final_i,
  input  logic          usr_i,
  input  logic          wr_i,
  input  logic          wp_i,
  output logic          present_o,
  output logic          viol_o,
  output logic          wr_ok_o,
  output logic [AW-1:0] upd_o,
  output logic          changed_o
);
  logic [AW-1:0] eff;
  logic          eff_u;
  logic          eff_rw;

  always_comb begin
    eff       = combine_i ? (ent_i & dir_i) : ent_i;
    eff_u     = eff[BIT_USR];
    eff_rw    = eff[BIT_RW];
    present_o = ent_i[BIT_PRES];
    if (usr_i) viol_o = !eff_u || (wr_i && !eff_rw);
    else       viol_o = wp_i && wr_i && !eff_rw;
    upd_o            = ent_i;
    upd_o[BIT_ACC]   = 1'b1;
    if (final_i && wr_i) upd_o[BIT_DIRTY] = 1'b1;
    changed_o = (upd_o != ent_i);
    if (usr_i) wr_ok_o = upd_o[BIT_DIRTY] && eff_rw;
    else       wr_ok_o = upd_o[BIT_DIRTY] && (!wp_i || eff_rw);
  end
endmodule

// File: rtl/pt_walker_ctrl.sv
module pt_walker_ctrl
  import pt_walker_pkg::*;
#(
  parameter int AW    = 32,
  parameter int OFF_W = 12,
  parameter int IDX_W = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic [AW-1:0]      va_i,
  input  logic               wr_i,
  input  logic               usr_i,
  input  logic               pg_i,
  input  logic               wp_i,
  input  logic               pse_i,
  input  logic [AW-1:0]      keep_i,
  input  logic [AW-1:0]      dir_addr_i,
  input  logic [AW-1:0]      tbl_addr_i,
  input  logic               present_i,
  input  logic               viol_i,
  input  logic               wr_ok_i,
  input  logic [AW-1:0]      upd_i,
  input  logic               changed_i,
  output logic               combine_o,
  output logic               final_o,
  output logic               usr_q_o,
  output logic               wr_q_o,
  output logic               wp_q_o,
  output logic [AW-1:0]      dir_q_o,
  output logic [AW-1:0]      va_q_o,
  output logic [AW-1:0]      keep_q_o,
  output logic               mem_req,
  output logic               mem_we,
  output logic [AW-1:0]      mem_addr,
  output logic [AW-1:0]      mem_wdata,
  input  logic               mem_ack,
  input  logic [AW-1:0]      mem_rdata,
  output logic               busy_o,
  output logic               done_o,
  output logic               fault_o,
  output logic [ERR_W-1:0]   code_o,
  output logic [AW-1:0]      fault_va_o,
  output logic [AW-OFF_W-1:0] frame_o,
  output logic               big_o,
  output logic               can_wr_o
);
  localparam int FRM_W = AW - OFF_W;
  localparam int HI_LO = OFF_W + IDX_W;

  walk_st_e          st;
  logic              pse_q;
  logic              big_sel;
  logic [FRM_W-1:0]  big_frame;
  logic [FRM_W-1:0]  small_frame;
  logic              pend_fault;
  logic [ERR_W-1:0]  pend_code;
  logic [FRM_W-1:0]  pend_frame;
  logic              pend_big;
  logic              pend_wr;
  logic [AW-1:0]     last_rd_q;

  always_comb begin
    big_sel     = mem_rdata[BIT_BIG] && pse_q;
    combine_o   = (st == ST_TBL_RD);
    final_o     = (st == ST_TBL_RD) || big_sel;
    big_frame   = {mem_rdata[AW-1:HI_LO], va_q_o[HI_LO-1:OFF_W]} & keep_q_o[AW-1:OFF_W];
    small_frame = upd_i[AW-1:OFF_W] & keep_q_o[AW-1:OFF_W];
    busy_o      = (st != ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      pse_q      <= 1'b0;
      usr_q_o    <= 1'b0;
      wr_q_o     <= 1'b0;
      wp_q_o     <= 1'b0;
      dir_q_o    <= '0;
      va_q_o     <= '0;
      keep_q_o   <= '0;
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      done_o     <= 1'b0;
      fault_o    <= 1'b0;
      code_o     <= '0;
      fault_va_o <= '0;
      frame_o    <= '0;
      big_o      <= 1'b0;
      can_wr_o   <= 1'b0;
      pend_fault <= 1'b0;
      pend_code  <= '0;
      pend_frame <= '0;
      pend_big   <= 1'b0;
      pend_wr    <= 1'b0;
      last_rd_q  <= '0;
    end else begin
      done_o <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start_i) begin
            va_q_o     <= va_i;
            wr_q_o     <= wr_i;
            usr_q_o    <= usr_i;
            wp_q_o     <= wp_i;
            pse_q      <= pse_i;
            keep_q_o   <= keep_i;
            pend_fault <= 1'b0;
            pend_code  <= '0;
            pend_big   <= 1'b0;
            if (!pg_i) begin
              pend_frame <= va_i[AW-1:OFF_W] & keep_i[AW-1:OFF_W];
              pend_wr    <= 1'b1;
              st         <= ST_FIN;
            end else begin
              mem_req  <= 1'b1;
              mem_we   <= 1'b0;
              mem_addr <= dir_addr_i;
              st       <= ST_DIR_RD;
            end
          end
        end
        ST_DIR_RD: begin
          if (mem_ack) begin
            last_rd_q <= mem_rdata;
            if (!present_i || (big_sel && viol_i)) begin
              pend_fault <= 1'b1;
              pend_code  <= {usr_q_o, wr_q_o, present_i};
              pend_wr    <= 1'b0;
              mem_req    <= 1'b0;
              st         <= ST_FIN;
            end else begin
              dir_q_o <= upd_i;
              if (big_sel) begin
                pend_frame <= big_frame;
                pend_wr    <= wr_ok_i;
                pend_big   <= 1'b1;
              end
              if (changed_i) begin
                mem_we    <= 1'b1;
                mem_wdata <= upd_i;
                st        <= ST_DIR_WB;
              end else begin
                mem_req <= 1'b0;
                st      <= big_sel ? ST_FIN : ST_TBL_GO;
              end
            end
          end
        end
        ST_DIR_WB: begin
          if (mem_ack) begin
            mem_req <= 1'b0;
            mem_we  <= 1'b0;
            st      <= pend_big ? ST_FIN : ST_TBL_GO;
          end
        end
        ST_TBL_GO: begin
          mem_req  <= 1'b1;
          mem_we   <= 1'b0;
          mem_addr <= tbl_addr_i;
          st       <= ST_TBL_RD;
        end
        ST_TBL_RD: begin
          if (mem_ack) begin
            last_rd_q <= mem_rdata;
            if (!present_i || viol_i) begin
              pend_fault <= 1'b1;
              pend_code  <= {usr_q_o, wr_q_o, present_i};
              pend_wr    <= 1'b0;
              mem_req    <= 1'b0;
              st         <= ST_FIN;
            end else begin
              pend_frame <= small_frame;
              pend_wr    <= wr_ok_i;
              if (changed_i) begin
                mem_we    <= 1'b1;
                mem_wdata <= upd_i;
                st        <= ST_TBL_WB;
              end else begin
                mem_req <= 1'b0;
                st      <= ST_FIN;
              end
            end
          end
        end
        ST_TBL_WB: begin
          if (mem_ack) begin
            mem_req <= 1'b0;
            mem_we  <= 1'b0;
            st      <= ST_FIN;
          end
        end
        ST_FIN: begin
          done_o   <= 1'b1;
          fault_o  <= pend_fault;
          code_o   <= pend_code;
          can_wr_o <= pend_wr;
          if (pend_fault) begin
            fault_va_o <= va_q_o;
          end else begin
            frame_o <= pend_frame;
            big_o   <= pend_big;
          end
          st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  a_r10_req_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
  a_r10_we_needs_req: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_req);
  a_r10_busy_excl_done: assert property (@(posedge clk) disable iff (rst)
    !(busy_o && done_o));
  a_r7_wb_sets_acc: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> mem_wdata[BIT_ACC]);
  a_r7_wb_only_on_change: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> (mem_wdata != last_rd_q));
  a_r6_fault_no_write: assert property (@(posedge clk) disable iff (rst)
    (done_o && fault_o) |-> !can_wr_o);
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int AW    = 32,
  parameter int OFF_W = 12,
  parameter int IDX_W = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 walk_start,
  input  logic [AW-1:0]        walk_va,
  input  logic                 walk_wr,
  input  logic                 walk_usr,
  input  logic                 paging_on,
  input  logic                 wr_protect,
  input  logic                 big_pages_on,
  input  logic [AW-1:0]        dir_base,
  input  logic [AW-1:0]        a20_keep,
  output logic                 mem_req,
  output logic                 mem_we,
  output logic [AW-1:0]        mem_addr,
  output logic [AW-1:0]        mem_wdata,
  input  logic                 mem_ack,
  input  logic [AW-1:0]        mem_rdata,
  output logic                 walk_busy,
  output logic                 walk_done,
  output logic                 walk_fault,
  output logic [ERR_W-1:0]     fault_code,
  output logic [AW-1:0]        fault_va,
  output logic [AW-OFF_W-1:0]  phys_frame,
  output logic                 big_page,
  output logic                 can_write
);
  logic [AW-1:0] dir_addr;
  logic [AW-1:0] tbl_addr;
  logic [AW-1:0] dir_q;
  logic [AW-1:0] va_q;
  logic [AW-1:0] keep_q;
  logic          combine;
  logic          final_ent;
  logic          usr_q;
  logic          wr_q;
  logic          wp_q;
  logic          present;
  logic          viol;
  logic          wr_ok;
  logic [AW-1:0] upd;
  logic          changed;

  pt_walker_ent_addr #(.AW(AW), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_dir_addr (
    .base_i (dir_base),
    .idx_i  (walk_va[AW-1 -: IDX_W]),
    .keep_i (a20_keep),
    .addr_o (dir_addr)
  );

  pt_walker_ent_addr #(.AW(AW), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_tbl_addr (
    .base_i (dir_q),
    .idx_i  (va_q[OFF_W +: IDX_W]),
    .keep_i (keep_q),
    .addr_o (tbl_addr)
  );

  pt_walker_rights #(.AW(AW)) u_rights (
    .ent_i     (mem_rdata),
    .dir_i     (dir_q),
    .combine_i (combine),
    .final_i   (final_ent),
    .usr_i     (usr_q),
    .wr_i      (wr_q),
    .wp_i      (wp_q),
    .present_o (present),
    .viol_o    (viol),
    .wr_ok_o   (wr_ok),
    .upd_o     (upd),
    .changed_o (changed)
  );

  pt_walker_ctrl #(.AW(AW), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start_i    (walk_start),
    .va_i       (walk_va),
    .wr_i       (walk_wr),
    .usr_i      (walk_usr),
    .pg_i       (paging_on),
    .wp_i       (wr_protect),
    .pse_i      (big_pages_on),
    .keep_i     (a20_keep),
    .dir_addr_i (dir_addr),
    .tbl_addr_i (tbl_addr),
    .present_i  (present),
    .viol_i     (viol),
    .wr_ok_i    (wr_ok),
    .upd_i      (upd),
    .changed_i  (changed),
    .combine_o  (combine),
    .final_o    (final_ent),
    .usr_q_o    (usr_q),
    .wr_q_o     (wr_q),
    .wp_q_o     (wp_q),
    .dir_q_o    (dir_q),
    .va_q_o     (va_q),
    .keep_q_o   (keep_q),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata),
    .busy_o     (walk_busy),
    .done_o     (walk_done),
    .fault_o    (walk_fault),
    .code_o     (fault_code),
    .fault_va_o (fault_va),
    .frame_o    (phys_frame),
    .big_o      (big_page),
    .can_wr_o   (can_write)
  );
endmodule

// File: tb/pt_walker_tb.sv
module pt_walker_tb_top;
  localparam int CLK_NS = 10;
  localparam int MEM_WORDS = 4096;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        walk_start = 1'b0;
  logic [31:0] walk_va = '0;
  logic        walk_wr = 1'b0, walk_usr = 1'b0, paging_on = 1'b0;
  logic        wr_protect = 1'b0, big_pages_on = 1'b0;
  logic [31:0] dir_base = '0, a20_keep = '1;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        walk_busy, walk_done, walk_fault, big_page, can_write;
  logic [2:0]  fault_code;
  logic [31:0] fault_va;
  logic [19:0] phys_frame;

  logic [31:0] mem [0:MEM_WORDS-1];
  logic        bk_we = 1'b0;
  logic [31:0] bk_addr = '0, bk_data = '0;
  logic        clr_log = 1'b0;
  int          rd_cnt, wr_cnt;
  logic [31:0] rd_a0, rd_a1, wr_a, wr_d;
  int          n_chk = 0, n_fail = 0;

  always #(CLK_NS/2) clk = ~clk;

  pt_walker dut_i (
    .clk(clk), .rst(rst), .walk_start(walk_start), .walk_va(walk_va),
    .walk_wr(walk_wr), .walk_usr(walk_usr), .paging_on(paging_on),
    .wr_protect(wr_protect), .big_pages_on(big_pages_on), .dir_base(dir_base),
    .a20_keep(a20_keep), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .walk_busy(walk_busy), .walk_done(walk_done), .walk_fault(walk_fault),
    .fault_code(fault_code), .fault_va(fault_va), .phys_frame(phys_frame),
    .big_page(big_page), .can_write(can_write)
  );

  always @(posedge clk) begin
    if (rst) begin
      mem_ack <= 1'b0;
      mem_rdata <= '0;
      rd_cnt <= 0; wr_cnt <= 0;
      rd_a0 <= '0; rd_a1 <= '0; wr_a <= '0; wr_d <= '0;
      for (int i = 0; i < MEM_WORDS; i++) mem[i] <= '0;
    end else begin
      if (bk_we) mem[bk_addr[13:2]] <= bk_data;
      if (clr_log) begin rd_cnt <= 0; wr_cnt <= 0; end
      if (mem_req && !mem_ack) begin
        mem_ack <= 1'b1;
        if (mem_we) begin
          mem[mem_addr[13:2]] <= mem_wdata;
          wr_cnt <= wr_cnt + 1; wr_a <= mem_addr; wr_d <= mem_wdata;
        end else begin
          mem_rdata <= mem[mem_addr[13:2]];
          if (rd_cnt == 0) rd_a0 <= mem_addr;
          else if (rd_cnt == 1) rd_a1 <= mem_addr;
          rd_cnt <= rd_cnt + 1;
        end
      end else begin
        mem_ack <= 1'b0;
      end
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not complete (actual hung, expected finished)");
    summary();
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); bk_we = 1'b1; bk_addr = a; bk_data = d;
    @(negedge clk); bk_we = 1'b0;
  endtask

  task automatic walk(input logic [31:0] va, input logic wr, input logic usr,
                      input logic pg, input logic wp, input logic pse,
                      input logic [31:0] root, input logic [31:0] keep);
    bit seen = 0;
    @(negedge clk);
    clr_log = 1'b1; walk_va = va; walk_wr = wr; walk_usr = usr; paging_on = pg;
    wr_protect = wp; big_pages_on = pse; dir_base = root; a20_keep = keep;
    @(negedge clk); clr_log = 1'b0; walk_start = 1'b1;
    @(negedge clk); walk_start = 1'b0;
    for (int k = 0; k < 200; k++) begin
      if (walk_done) begin seen = 1; break; end
      @(negedge clk);
    end
    chk("R10 walk completes", 32'(seen), 32'd1);
  endtask

  task automatic t_reset();
    chk("R10 reset busy", 32'(walk_busy), 0);
    chk("R10 reset done", 32'(walk_done), 0);
    chk("R10 reset req", 32'(mem_req), 0);
  endtask

  task automatic t_no_paging();
    walk(32'h12345678, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 32'h1000, 32'hFFFFFFFF);
    chk("R1 frame", 32'(phys_frame), 32'h12345);
    chk("R1 can_write", 32'(can_write), 1);
    chk("R1 no fault", 32'(walk_fault), 0);
    chk("R1 no reads", rd_cnt, 0);
  endtask

  task automatic t_small_rw();
    walk(32'h00403ABC, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 32'h1000, 32'hFFFFFFFF);
    chk("R2 dir addr", rd_a0, 32'h1004);
    chk("R3 tbl addr", rd_a1, 32'h200C);
    chk("R7 dir gets A only", wr_d, 32'h2027);
    chk("R7 one write", wr_cnt, 1);
    chk("R3 frame", 32'(phys_frame), 32'h0ABCD);
    chk("R8 clean read no write right", 32'(can_write), 0);
    walk(32'h00403ABC, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 32'h1000, 32'hFFFFFFFF);
    chk("R7 write sets dirty addr", wr_a, 32'h200C);
    chk("R7 write sets dirty data", wr_d, 32'h0ABCD067);
    chk("R7 unchanged dir not written", wr_cnt, 1);
    chk("R8 dirty write right", 32'(can_write), 1);
    walk(32'h00403ABC, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 32'h1000, 32'hFFFFFFFF);
    chk("R7 no write when unchanged", wr_cnt, 0);
    chk("R8 dirty read write right", 32'(can_write), 1);
  endtask

  task automatic t_faults();
    walk(32'h00404000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 32'h1000, 32'hFFFFFFFF);
    chk("R5 user without U faults", 32'(walk_fault), 1);
    chk("R6 code protect user read", 32'(fault_code), 32'b101);
    chk("R6 fault va", fault_va, 32'h00404000);
    chk("R6 no write-back on fault", wr_cnt, 0);
    walk(32'h00800123, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 32'h1000, 32'hFFFFFFFF);
    chk("R6 code not present", 32'(fault_code), 32'b110);
    chk("R6 fault va np", fault_va, 32'h00800123);
    chk("R6 one read only", rd_cnt, 1);
    chk("R6 fault clears write right", 32'(can_write), 0);
  endtask

  task automatic t_supervisor_wp();
    walk(32'h00405000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 32'h1000, 32'hFFFFFFFF);
    chk("R5 sup write RO with WP faults", 32'(walk_fault), 1);
    chk("R6 code sup write", 32'(fault_code), 32'b011);
    walk(32'h00405000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 32'h1000, 32'hFFFFFFFF);
    chk("R5 sup write RO without WP ok", 32'(walk_fault), 0);
    chk("R8 sup no WP write right", 32'(can_write), 1);
    chk("R7 sup write dirty", wr_d, 32'h0CCCC061);
    walk(32'h00405000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 32'h1000, 32'hFFFFFFFF);
    chk("R8 dirty RO with WP no write", 32'(can_write), 0);
  endtask

  task automatic t_large();
    walk(32'h00C56789, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 32'h1000, 32'hFFFFFFFF);
    chk("R4 large single read", rd_cnt, 1);
    chk("R4 large flag", 32'(big_page), 1);
    chk("R4 large frame", 32'(phys_frame), 32'h1C056);
    chk("R8 large dirty write right", 32'(can_write), 1);
    walk(32'h00C56789, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 32'h1000, 32'hFFFFFFFF);
    chk("R4 pse off walks table", rd_cnt, 2);
    chk("R4 pse off tbl addr", rd_a1, 32'h1C000158);
    chk("R4 pse off not large", 32'(big_page), 0);
    chk("R4 pse off frame", 32'(phys_frame), 32'h0DDDD);
    walk(32'h01012345, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 32'h1000, 32'hFFFFFFFF);
    chk("R7 large write addr", wr_a, 32'h1010);
    chk("R7 large write A and D", wr_d, 32'h200000E7);
    chk("R4 large clean frame", 32'(phys_frame), 32'h20012);
    chk("R8 large write right", 32'(can_write), 1);
  endtask

  task automatic t_a20();
    walk(32'h00403ABC, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 32'h00101000, 32'hFFEFFFFF);
    chk("R9 dir addr masked", rd_a0, 32'h1004);
    chk("R9 frame masked", 32'(phys_frame), 32'h0AACD);
    chk("R9 no fault", 32'(walk_fault), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    // directory at 0x1000, table at 0x2000; bits: 0 P, 1 RW, 2 U, 5 A, 6 D, 7 PS
    poke(32'h1004, 32'h00002007);
    poke(32'h100C, 32'h1C0000E7);
    poke(32'h1010, 32'h20000087);
    poke(32'h200C, 32'h0ABCD027);
    poke(32'h2010, 32'h0BBBB023);
    poke(32'h2014, 32'h0CCCC021);
    poke(32'h0158, 32'h0DDDD067);
    t_no_paging();
    t_small_rw();
    t_faults();
    t_supervisor_wp();
    t_large();
    t_a20();
    summary();
  end
endmodule